// File: doc/BRIEF.md
# Synchronous Half-Duplex Shift Port

This block is a master-only serial shifter that moves one byte at a time over a single shared data line. It always drives the shift clock, in both directions. Writing a byte to the data buffer while the port is idle sends that byte out, least significant bit first. There are no framing bits. Reception needs no start bit. It begins on its own whenever the port is idle, receive is enabled and the receive-done flag is clear.

The data line is open-drain. The block can only pull it low (`sdaPullLow`) or release it, and it reads the line level back on `sdaIn`. Every bit lasts one period of `DIV` system clocks. In each period the shift clock is low for the first half and high for the second half. Transmit data changes only while the clock is low. Receive data is taken on the rising clock edge.

Two sticky flags report completed transfers. They are cleared by write-one-to-clear strobes, and they raise an interrupt request when interrupts are enabled. A set receive-done flag stops any further reception until software clears it.

Top module: `sync_shift_port`

## Requirements
- R1: While a transfer runs, `sclOut` is low for the first `DIV/2` clocks and high for the last `DIV/2` clocks of each `DIV`-clock bit period. While idle, `sclOut` is 1 and `sdaPullLow` is 0.
- R2: A `wrData` pulse while idle starts a transmit of `wrByte`. Exactly 8 bits go out with no framing, bit 0 first. Each bit is on the line for a whole period, and the line can be read at each rising edge of `sclOut`.
- R3: `txDone` becomes 1 exactly 8*`DIV` (96) clock edges after the edge that takes the write.
- R4: A receive arms on a clock edge where the port is idle, `rxEnable` is 1, `rxDone` is 0 and no write is present. The first bit period starts right away, so `sclOut` goes low. Each bit is sampled from `sdaIn` on the rising edge of `sclOut`.
- R5: `rxDone` becomes 1 one clock after the 8th sample, which is 7*`DIV`+`DIV/2`+1 (91) edges after the arming edge. `rdData` then holds the received byte, with the first bit received in bit 0.
- R6: While `rxDone` is 1, no reception starts: `sclOut` stays 1 even with `rxEnable` held at 1.
- R7: `sdaPullLow` is 1 only during a transmit bit whose value is 0. It is never 1 during a receive.
- R8: `irq` equals `intEnable` AND (`txDone` OR `rxDone`).
- R9: A 1 on `clrTxDone` or `clrRxDone` clears the matching flag on the next edge.
- R10: A `wrData` pulse during a transmit or a receive is ignored. The byte in flight is unchanged, and no extra transmit follows.
- R11: If a write and a receive arm occur on the same edge, the transmit wins and no receive starts on that edge.
- R12: `rdData` shows the byte of the last completed transfer (received or sent) and holds it until the next transfer completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrData | input | 1 | Data buffer write strobe |
| wrByte | input | 8 | Byte to transmit |
| rxEnable | input | 1 | Receive enable level |
| intEnable | input | 1 | Interrupt enable |
| clrTxDone | input | 1 | Write-one-to-clear for txDone |
| clrRxDone | input | 1 | Write-one-to-clear for rxDone |
| rdData | output | 8 | Data buffer read value |
| txDone | output | 1 | Transmit complete flag |
| rxDone | output | 1 | Receive complete flag |
| irq | output | 1 | Interrupt request |
| sdaIn | input | 1 | Data line level |
| sdaPullLow | output | 1 | Open-drain pull-down of the data line |
| sclOut | output | 1 | Shift clock |

## Verification
`txDone` is due on the 96th edge after the write edge. `rxDone` is due on the 91st edge after the arming edge. The bench counts falling clock edges from the edge that takes the strobe, checks that the flag is still 0 one edge early, and then checks that it is 1 on the due edge. Transmitted bits are read at each rising edge of `sclOut`, when the line is stable. Receive bits are driven on each falling edge of `sclOut`. Flag clears and re-arming are checked one edge after the strobe.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef struct packed {
    logic loadTx;
    logic shiftTx;
    logic sampleRx;
    logic doneTx;
    logic doneRx;
  } sspStrobes_t;
endpackage

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int DIV  = 12,
  parameter int BITS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrData,
  input  logic        rxEnable,
  input  logic        rxDone,
  output sspStrobes_t strb,
  output logic        txActive,
  output logic        rxActive,
  output logic        sclOut
);
  localparam int HALF = DIV / 2;
  localparam int PW   = $clog2(DIV);
  localparam int BW   = (BITS > 1) ? $clog2(BITS) : 1;

  typedef enum logic [1:0] {IDLE, TX, RX} portState_t;

  portState_t       state;
  logic [PW-1:0]    phase;
  logic [BW-1:0]    bitIdx;
  logic             startTx, startRx, periodEnd, lastBit;

  always_comb begin
    startTx       = (state == IDLE) && wrData;
    startRx       = (state == IDLE) && !wrData && rxEnable && !rxDone;
    periodEnd     = (phase == PW'(DIV - 1));
    lastBit       = (bitIdx == BW'(BITS - 1));
    strb.loadTx   = startTx;
    strb.shiftTx  = (state == TX) && periodEnd;
    strb.doneTx   = (state == TX) && periodEnd && lastBit;
    strb.sampleRx = (state == RX) && (phase == PW'(HALF - 1));
    strb.doneRx   = (state == RX) && lastBit && (phase == PW'(HALF));
    txActive      = (state == TX);
    rxActive      = (state == RX);
    sclOut        = (state == IDLE) || (phase >= PW'(HALF));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= IDLE;
      phase  <= '0;
      bitIdx <= '0;
    end else begin
      unique case (state)
        IDLE: begin
          phase  <= '0;
          bitIdx <= '0;
          if (startTx)      state <= TX;
          else if (startRx) state <= RX;
        end
        TX: begin
          if (periodEnd) begin
            phase  <= '0;
            bitIdx <= bitIdx + 1'b1;
            if (lastBit) state <= IDLE;
          end else begin
            phase <= phase + 1'b1;
          end
        end
        RX: begin
          if (strb.doneRx) begin
            state <= IDLE;
            phase <= '0;
          end else if (periodEnd) begin
            phase  <= '0;
            bitIdx <= bitIdx + 1'b1;
          end else begin
            phase <= phase + 1'b1;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ssp_datapath.sv
module ssp_datapath
  import ssp_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  sspStrobes_t     strb,
  input  logic            txActive,
  input  logic [BITS-1:0] wrByte,
  input  logic            sdaIn,
  input  logic            clrTxDone,
  input  logic            clrRxDone,
  input  logic            intEnable,
  output logic [BITS-1:0] rdData,
  output logic            txDone,
  output logic            rxDone,
  output logic            irq,
  output logic            sdaPullLow
);
  logic [BITS-1:0] shiftReg;
  logic [BITS-1:0] txHold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '1;
      txHold   <= '0;
      rdData   <= '0;
      txDone   <= 1'b0;
      rxDone   <= 1'b0;
    end else begin
      if (strb.loadTx) begin
        shiftReg <= wrByte;
        txHold   <= wrByte;
      end else if (strb.shiftTx) begin
        shiftReg <= {1'b1, shiftReg[BITS-1:1]};
      end else if (strb.sampleRx) begin
        shiftReg <= {sdaIn, shiftReg[BITS-1:1]};
      end
      if (strb.doneTx)      rdData <= txHold;
      else if (strb.doneRx) rdData <= shiftReg;
      txDone <= strb.doneTx | (txDone & ~clrTxDone);
      rxDone <= strb.doneRx | (rxDone & ~clrRxDone);
    end
  end

  assign sdaPullLow = txActive & ~shiftReg[0];
  assign irq        = intEnable & (txDone | rxDone);
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
  import ssp_pkg::*;
#(
  parameter int DIV  = 12,
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrData,
  input  logic [BITS-1:0] wrByte,
  input  logic            rxEnable,
  input  logic            intEnable,
  input  logic            clrTxDone,
  input  logic            clrRxDone,
  output logic [BITS-1:0] rdData,
  output logic            txDone,
  output logic            rxDone,
  output logic            irq,
  input  logic            sdaIn,
  output logic            sdaPullLow,
  output logic            sclOut
);
  sspStrobes_t strb;
  logic        txActive, rxActive;

  ssp_ctrl #(.DIV(DIV), .BITS(BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrData(wrData), .rxEnable(rxEnable),
    .rxDone(rxDone), .strb(strb), .txActive(txActive),
    .rxActive(rxActive), .sclOut(sclOut)
  );

  ssp_datapath #(.BITS(BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .txActive(txActive),
    .wrByte(wrByte), .sdaIn(sdaIn), .clrTxDone(clrTxDone),
    .clrRxDone(clrRxDone), .intEnable(intEnable), .rdData(rdData),
    .txDone(txDone), .rxDone(rxDone), .irq(irq), .sdaPullLow(sdaPullLow)
  );
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
  input logic clk,
  input logic rstN,
  input logic txActive,
  input logic rxActive,
  input logic txDone,
  input logic rxDone,
  input logic clrRxDone,
  input logic sclOut,
  input logic sdaPullLow
);
  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!txActive && !rxActive) |-> (sclOut && !sdaPullLow));

  // R2
  tx_data_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txActive && $past(txActive) && sclOut && $past(sclOut)) |-> $stable(sdaPullLow));

  // R3
  tx_done_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txDone) |-> $past(txActive));

  // R6
  rx_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && !clrRxDone) |=> !rxActive);

  // R7
  rx_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxActive |-> !sdaPullLow);

  // R10
  one_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({txActive, rxActive}));
endmodule

bind sync_shift_port ssp_checker u_chk (
  .clk(clk), .rstN(rstN), .txActive(txActive), .rxActive(rxActive),
  .txDone(txDone), .rxDone(rxDone), .clrRxDone(clrRxDone),
  .sclOut(sclOut), .sdaPullLow(sdaPullLow)
);

// File: tb/test_sync_shift_port.sv
module test_sync_shift_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrData = 1'b0;
  logic [7:0] wrByte = '0;
  logic       rxEnable = 1'b0, intEnable = 1'b0;
  logic       clrTxDone = 1'b0, clrRxDone = 1'b0;
  logic [7:0] rdData;
  logic       txDone, rxDone, irq, sdaIn, sdaPullLow, sclOut;
  logic       sdaDrive = 1'b1;
  int         checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sdaIn = sdaPullLow ? 1'b0 : sdaDrive;

  sync_shift_port i_sync_shift_port (
    .clk(clk), .rstN(rstN), .wrData(wrData), .wrByte(wrByte),
    .rxEnable(rxEnable), .intEnable(intEnable), .clrTxDone(clrTxDone),
    .clrRxDone(clrRxDone), .rdData(rdData), .txDone(txDone),
    .rxDone(rxDone), .irq(irq), .sdaIn(sdaIn), .sdaPullLow(sdaPullLow),
    .sclOut(sclOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulseClr(input bit tx);
    @(negedge clk);
    if (tx) clrTxDone = 1'b1; else clrRxDone = 1'b1;
    @(negedge clk);
    clrTxDone = 1'b0;
    clrRxDone = 1'b0;
  endtask

  // Transmit scenario: optional mid-transfer write (R10), optional same-cycle arm (R11)
  task automatic runTx(input logic [7:0] val, input bit poke, input bit withRx);
    logic [7:0] seen;
    @(negedge clk);
    wrByte = val; wrData = 1'b1; rxEnable = withRx;
    @(negedge clk);
    wrData = 1'b0;
    fork
      begin
        for (int i = 0; i < 8; i++) begin
          @(posedge sclOut);
          seen[i] = ~sdaPullLow;
        end
      end
      begin
        repeat (40) @(negedge clk);
        if (poke) begin
          wrByte = ~val; wrData = 1'b1;
          @(negedge clk);
          wrData = 1'b0;
        end else @(negedge clk);
        repeat (54) @(negedge clk);
        check("R3 txDone one edge early", txDone, 0);
        @(negedge clk);
        check("R3 txDone on due edge", txDone, 1);
        rxEnable = 1'b0;
      end
    join
    check("R2 transmitted bits LSB first", seen, val);
    check("R12 buffer holds sent byte", rdData, val);
    if (withRx) check("R11 no receive alongside transmit", rxDone, 0);
    intEnable = 1'b0;
    #1 check("R8 irq masked", irq, 0);
    intEnable = 1'b1;
    #1 check("R8 irq on txDone", irq, 1);
    repeat (3) @(negedge clk);
    check("R10 no extra transmit", sclOut, 1);
    pulseClr(1'b1);
    check("R9 txDone cleared", txDone, 0);
    check("R8 irq dropped", irq, 0);
    intEnable = 1'b0;
  endtask

  // Receive scenario: blocking while rxDone (R6), re-arm after clear (R4)
  task automatic runRx(input logic [7:0] val, input bit poke);
    logic [7:0] prev;
    bit sawLow, sawPull;
    prev = rdData;
    fork
      begin
        for (int i = 0; i < 8; i++) begin
          @(negedge sclOut);
          #1 sdaDrive = val[i];
        end
      end
      begin
        @(negedge clk);
        rxEnable = 1'b1;
        @(negedge clk);
        check("R4 clock low after arm", sclOut, 0);
        sawPull = 1'b0;
        for (int i = 0; i < 30; i++) begin
          @(negedge clk);
          sawPull |= sdaPullLow;
          if (i == 2) check("R1 clock low in first half", sclOut, 0);
          if (i == 5) check("R1 clock high in second half", sclOut, 1);
        end
        if (poke) begin
          wrByte = 8'h00; wrData = 1'b1;
          @(negedge clk);
          wrData = 1'b0;
        end else @(negedge clk);
        for (int i = 0; i < 59; i++) begin
          @(negedge clk);
          sawPull |= sdaPullLow;
        end
        check("R7 no pull during receive", sawPull, 0);
        check("R5 rxDone one edge early", rxDone, 0);
        check("R12 buffer holds old byte mid-receive", rdData, prev);
        @(negedge clk);
        check("R5 rxDone on due edge", rxDone, 1);
      end
    join
    sdaDrive = 1'b1;
    check("R5 received byte", rdData, val);
    check("R10 write during receive ignored", txDone, 0);
    sawLow = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      sawLow |= ~sclOut;
    end
    check("R6 no reception while rxDone", sawLow, 0);
    pulseClr(1'b0);
    check("R9 rxDone cleared", rxDone, 0);
    @(negedge clk);
    check("R4 re-arm after clear", sclOut, 0);
    rxEnable = 1'b0;
    repeat (100) @(negedge clk);
    pulseClr(1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle clock high", sclOut, 1);
    check("R1 idle line released", sdaPullLow, 0);
    check("R3 reset txDone", txDone, 0);
    check("R5 reset rxDone", rxDone, 0);
    check("R8 reset irq", irq, 0);
    runTx(8'hA5, 1'b0, 1'b0);
    runTx(8'h3C, 1'b1, 1'b0);
    runRx(8'h96, 1'b0);
    runRx(8'h41, 1'b1);
    runTx(8'h7E, 1'b0, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule